// File: doc/BRIEF.md
# SHA-512 Message Schedule Completion Unit

This block produces the last step of the SHA-512 message expansion for four consecutive new schedule words. One operand, `part_sum`, carries four 64-bit partial sums that already hold the W[t-16], sigma-0 and W[t-7] terms. The other operand, `recent_w`, carries the two most recent schedule words in its two upper qwords (qword 2 is W[t-2] for the first new word, qword 3 is W[t-1] for the second). Its lower two qwords are ignored. The block adds the small sigma-1 term of the proper older word to each partial sum.

The four lanes are not independent. New words 0 and 1 use sigma-1 of the two recent words from `recent_w`. New words 2 and 3 use sigma-1 of new words 0 and 1, which are computed in the same operation. The datapath is therefore two chained sigma/add levels. The parameter `PIPE_SPLIT` selects one of two structures. With 0, both levels sit before a single result register, so latency is 1 cycle. With 1, a register sits between the levels, so latency is 2 cycles.

An operation is accepted on any clock edge where both `in_valid` and `in_ready` are high, and one can be accepted every cycle. Each pipeline slot has a two-state controller with the states EMPTY and FULL:
- EMPTY to FULL when data loads.
- FULL to FULL on back-to-back loads.
- FULL to EMPTY on a bubble.
- EMPTY to EMPTY while idle.

`out_valid` is the output slot being FULL.

Top module: `sha512_wexp_tail`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are low. Out of reset, `in_ready` is high.
- R2: Result bits [63:0] equal `part_sum[63:0]` + s1(`recent_w[191:128]`), modulo 2^64.
- R3: Result bits [127:64] equal `part_sum[127:64]` + s1(`recent_w[255:192]`), modulo 2^64.
- R4: Result bits [191:128] equal `part_sum[191:128]` + s1(result bits [63:0]), chained on the new word.
- R5: Result bits [255:192] equal `part_sum[255:192]` + s1(result bits [127:64]), chained on the new word.
- R6: s1(x) = ror(x,19) XOR ror(x,61) XOR (x >> 6).
- R7: `recent_w[127:0]` has no effect on the result.
- R8: A result appears with `out_valid` high exactly 1 cycle after acceptance (2 when `PIPE_SPLIT`=1). Back-to-back inputs give back-to-back results.
- R9: A cycle with no accepted input gives `out_valid` low in the matching output cycle. `out_words` holds its value while no new result loads.
- R10: Sums wrap modulo 2^64, with no carry out of any lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept (high out of reset) |
| part_sum | input | 256 | Four partial sums, lane i in bits [64i+63:64i] |
| recent_w | input | 256 | Qwords 2 and 3 are the two latest schedule words; qwords 0 and 1 are ignored |
| out_valid | output | 1 | `out_words` holds a new result |
| out_words | output | 256 | Four completed schedule words, lane i in bits [64i+63:64i] |

## Verification
The sigma function is probed with single-bit recent words, which expose each rotate and shift amount on its own. All-ones partial sums force a carry out of every lane. Random vectors always carry random lower qwords in `recent_w`, and the chained result almost never matches a non-chained reading. A wrong source for lanes 2 and 3, or any dependence on the ignored qwords, therefore shows as a lane mismatch. Back-to-back streams with random bubbles separate correct latency and throughput from lost or duplicated results.

// File: rtl/wexp_pkg.sv
package wexp_pkg;
    localparam int WORD_W  = 64;
    localparam int LANES   = 4;
    localparam int VEC_W   = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    // small sigma-1: ror 19 ^ ror 61 ^ shr 6
    function automatic word_t sig1(input word_t x);
        return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ (x >> 6);
    endfunction
endpackage

// File: rtl/wexp_pair.sv
// One chain level: two lanes, each base + sigma1(source).
module wexp_pair
    import wexp_pkg::*;
#(
    parameter int PAIR = 2
) (
    input  word_t [PAIR-1:0] base,
    input  word_t [PAIR-1:0] src,
    output word_t [PAIR-1:0] sum
);
    for (genvar g = 0; g < PAIR; g++) begin : g_lane
        assign sum[g] = base[g] + sig1(src[g]);
    end
endmodule

// File: rtl/wexp_ctrl.sv
// Slot controller: one EMPTY/FULL state per pipeline slot.
module wexp_ctrl
    import wexp_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    output logic [STAGES-1:0] stage_load,
    output logic              out_valid
);
    slot_e [STAGES-1:0] st_q, st_d;
    logic  [STAGES-1:0] feed;

    for (genvar s = 0; s < STAGES; s++) begin : g_slot
        if (s == 0) begin : g_first
            assign feed[s] = accept;
        end else begin : g_next
            assign feed[s] = (st_q[s-1] == SLOT_FULL);
        end

        always_comb begin
            unique case (st_q[s])
                SLOT_EMPTY: st_d[s] = feed[s] ? SLOT_FULL : SLOT_EMPTY;
                SLOT_FULL:  st_d[s] = feed[s] ? SLOT_FULL : SLOT_EMPTY;
                default:    st_d[s] = SLOT_EMPTY;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[s] <= SLOT_EMPTY;
            else        st_q[s] <= st_d[s];
        end

        assign stage_load[s] = feed[s];
    end

    assign out_valid = (st_q[STAGES-1] == SLOT_FULL);

    if (STAGES == 1) begin : g_chk1
        a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> out_valid);
        a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
            !accept |=> !out_valid);
    end else begin : g_chk2
        a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> ##1 out_valid);
        a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
            !accept |=> ##1 !out_valid);
    end
endmodule

// File: rtl/sha512_wexp_tail.sv
module sha512_wexp_tail
    import wexp_pkg::*;
#(
    parameter int PIPE_SPLIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] part_sum,
    input  logic [VEC_W-1:0] recent_w,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_words
);
    localparam int STAGES = (PIPE_SPLIT != 0) ? 2 : 1;
    localparam int LAT    = STAGES;

    logic              accept;
    logic [STAGES-1:0] stage_load;
    word_t [1:0] lo_base, lo_src, lo_sum;
    word_t [1:0] hi_base, hi_src, hi_sum;

    assign in_ready = rst_n;
    assign accept   = in_valid && in_ready;

    wexp_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .stage_load (stage_load),
        .out_valid  (out_valid)
    );

    // level 1: lanes 0,1 from the two recent words
    assign lo_base[0] = part_sum[63:0];
    assign lo_base[1] = part_sum[127:64];
    assign lo_src[0]  = recent_w[191:128];
    assign lo_src[1]  = recent_w[255:192];

    wexp_pair #(.PAIR(2)) u_lvl1 (.base(lo_base), .src(lo_src), .sum(lo_sum));

    // level 2: lanes 2,3 chained on lanes 0,1
    word_t [1:0] mid_lo;
    if (STAGES == 2) begin : g_split
        word_t [1:0] mid_base_q, mid_lo_q;
        always_ff @(posedge clk) begin
            if (stage_load[0]) begin
                mid_base_q[0] <= part_sum[191:128];
                mid_base_q[1] <= part_sum[255:192];
                mid_lo_q      <= lo_sum;
            end
        end
        assign hi_base = mid_base_q;
        assign mid_lo  = mid_lo_q;
    end else begin : g_flat
        assign hi_base[0] = part_sum[191:128];
        assign hi_base[1] = part_sum[255:192];
        assign mid_lo     = lo_sum;
    end
    assign hi_src = mid_lo;

    wexp_pair #(.PAIR(2)) u_lvl2 (.base(hi_base), .src(hi_src), .sum(hi_sum));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   out_words <= '0;
        else if (stage_load[STAGES-1]) out_words <= {hi_sum[1], hi_sum[0], mid_lo[1], mid_lo[0]};
    end

    // R2: lane 0 against the operands seen LAT cycles earlier
    a_r2_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_words[63:0] ==
            $past(part_sum[63:0], LAT) + sig1($past(recent_w[191:128], LAT)));
    // R4: lane 2 chains on the delivered lane 0
    a_r4_chain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_words[191:128] - sig1(out_words[63:0]) ==
            $past(part_sum[191:128], LAT));
    // R5: lane 3 chains on the delivered lane 1
    a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_words[255:192] - sig1(out_words[127:64]) ==
            $past(part_sum[255:192], LAT));
    // R9: no load means the result register holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_load[STAGES-1] |=> $stable(out_words));
endmodule

// File: tb/sha512_wexp_tail_bench.sv
`timescale 1ns/1ps
module sha512_wexp_tail_bench;
    localparam int PIPE_SPLIT = 0;
    localparam int LAT = (PIPE_SPLIT != 0) ? 2 : 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [255:0] part_sum = '0;
    logic [255:0] recent_w = '0;
    logic out_valid;
    logic [255:0] out_words;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [255:0] exp_q[$];
    int           iss_q[$];
    logic [255:0] last_out = '0;
    logic         have_last = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sha512_wexp_tail #(.PIPE_SPLIT(PIPE_SPLIT)) u_sha512_wexp_tail (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .part_sum(part_sum), .recent_w(recent_w),
        .out_valid(out_valid), .out_words(out_words));

    // R6 model
    function automatic logic [63:0] m_sig1(input logic [63:0] x);
        return ((x >> 19) | (x << 45)) ^ ((x >> 61) | (x << 3)) ^ (x >> 6);
    endfunction

    function automatic logic [255:0] model(input logic [255:0] p, input logic [255:0] r);
        logic [63:0] w0, w1, w2, w3;
        w0 = p[63:0]    + m_sig1(r[191:128]);
        w1 = p[127:64]  + m_sig1(r[255:192]);
        w2 = p[191:128] + m_sig1(w0);
        w3 = p[255:192] + m_sig1(w1);
        return {w3, w2, w1, w0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [255:0] p, input logic [255:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        part_sum = p;
        recent_w = r;
        exp_q.push_back(model(p, r));
        iss_q.push_back(cyc + 1);
    endtask

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        part_sum = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9: actual=out_valid 1 expected=0 (no pending item)");
                end else begin
                    logic [255:0] e;
                    int iss;
                    e = exp_q.pop_front();
                    iss = iss_q.pop_front();
                    check("R2 lane0", out_words[63:0],    e[63:0]);
                    check("R3 lane1", out_words[127:64],  e[127:64]);
                    check("R4 lane2 chained", out_words[191:128], e[191:128]);
                    check("R5 lane3 chained", out_words[255:192], e[255:192]);
                    check("R8 latency", 64'(cyc), 64'(iss + LAT - 1));
                end
                last_out = out_words;
                have_last = 1'b1;
            end else if (rst_n && have_last) begin
                check("R9 hold", out_words[63:0] ^ out_words[255:192], last_out[63:0] ^ last_out[255:192]);
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [255:0] p, r;
        // R1 reset state
        #12;
        check("R1 out_valid in reset", 64'(out_valid), 64'd0);
        check("R1 in_ready in reset", 64'(in_ready), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", 64'(in_ready), 64'd1);
        check("R1 out_valid idle", 64'(out_valid), 64'd0);

        // R6: single-bit sources expose each rotate/shift
        drive('0, {64'h1, 64'h0, 128'h0});
        drive('0, {64'h0, 64'h8000_0000_0000_0000, 128'h0});
        drive('0, {64'h40, 64'h1_0000, 128'h0});
        // R10: all-ones partial sums force wrap
        drive({4{64'hFFFF_FFFF_FFFF_FFFF}}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 128'h0});
        drive({4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'hFFFF_FFFF_FFFF_FFFF}});
        bubble();
        // R7: identical useful operands, different ignored qwords
        p = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F, 64'hA5A5_A5A5_A5A5_A5A5};
        drive(p, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 128'h0});
        drive(p, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, {4{32'hDEAD_BEEF}}});
        bubble(); bubble();
        // R4/R5/R8/R9: random stream with random bubbles; lower recent qwords
        // are random, so a non-chained lane 2/3 would differ
        for (int i = 0; i < 60; i++) begin
            p = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 3) == 0) bubble();
            drive(p, r);
        end
        bubble();
        repeat (LAT + 3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: actual=%0d pending expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule